// File: doc/BRIEF.md
# DMA Transfer Bus-Cycle Sequencer

This block runs the bus accesses that move one DMA transfer unit from a source address to a destination address. A start pulse, given while the block is idle, captures the two addresses, the unit size (byte or 16-bit word), the data bus width (8 or 16 bits) and a 3-bit memory-region code for each side. The block then issues the read accesses and buffers the data internally. After that it issues the write accesses. It holds each access on the bus for the number of clocks its region needs.

A 16-bit unit is moved as one word access when the bus is 16 bits wide and that side's address is even. Otherwise it is moved as two byte accesses: first the low byte at the given address, then the high byte at that address plus one. The read side and the write side make this choice independently. When the unit is complete, a one-clock done pulse is raised and the total number of bus clocks used is reported. The bus has no handshake. Read data is taken in the last clock of each read access.

Top module: `dma_xfer_seq`

## Requirements
- R1: The clocks per access are set by the region code: 0→1, 1→2, 2→2, 3→1, 4→2, 5→3, 6→4, 7→3.
- R2: A byte unit (`unit_word`=0) makes exactly one byte read at `src_addr` and one byte write at `dst_addr`, on either bus width.
- R3: A word unit on a 16-bit bus (`bus_wide`=1) makes a single word access (`bus_byte`=0) on a side whose address has bit 0 clear.
- R4: A word unit makes two byte accesses on a side whose address is odd or when `bus_wide`=0: the first at the address, the second at the address plus one.
- R5: The first read starts in the clock after start is accepted. All reads of a unit come before its first write, and there are no idle clocks between accesses.
- R6: During each access `bus_req` is high, and `bus_addr`, `bus_we` and `bus_byte` stay constant for exactly the region's clock count.
- R7: Byte reads take `bus_rdata[7:0]`. Word reads take all 16 bits. A word write drives the whole buffered word. A byte write drives its byte on `bus_wdata[7:0]` with the upper byte zero: the low byte first, then the high byte.
- R8: `done` is high for exactly one clock, in the clock after the last write clock. From then on, `cycles` shows reads×read-coefficient + writes×write-coefficient and holds that value until the next accepted start.
- R9: A start pulse given while a unit is in progress, or in the done clock, is ignored. Inputs that change during a unit have no effect on it.
- R10: After reset, `bus_req`, `busy`, `done` and `cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a unit; accepted only when idle |
| src_addr | input | ADDR_W | Read address of the unit |
| dst_addr | input | ADDR_W | Write address of the unit |
| unit_word | input | 1 | 1 = 16-bit unit, 0 = 8-bit unit |
| bus_wide | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| src_region | input | 3 | Region code of the read side |
| dst_region | input | 3 | Region code of the write side |
| bus_req | output | 1 | An access is on the bus |
| bus_we | output | 1 | 1 = write access, 0 = read |
| bus_byte | output | 1 | 1 = byte access, 0 = word access |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken in the last clock of a read |
| busy | output | 1 | Reads or writes in progress |
| done | output | 1 | One-clock pulse when the unit is complete |
| cycles | output | TOT_W | Bus clocks used by the latest unit |

## Verification
The assertions assume the following about the inputs:
- `start` is acted on only in the idle state.
- `bus_rdata` is valid in the last clock of every read, because the fixed wait timing has no handshake.
- Every 3-bit region value is legal.

The bench drives all inputs half a clock away from the sampling edge. Its memory model returns data computed from `bus_addr` and `bus_byte`, so the read data is always valid when it is taken. It gives a start pulse only while idle, except in one deliberate test in the middle of a unit, which checks that the pulse is ignored. It also changes the inputs during that unit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int DATA_W  = 16;
    localparam int MAX_ACC = 2;
    localparam int MAX_MUL = 4;
    localparam int MUL_W   = $clog2(MAX_MUL + 1);
    localparam int TOT_W   = $clog2(2 * MAX_ACC * MAX_MUL + 1);

    typedef enum logic [2:0] {
        RG_ONCHIP_FAST = 3'd0,
        RG_ONCHIP_SLOW = 3'd1,
        RG_CTRL_SPACE  = 3'd2,
        RG_EXT_W0      = 3'd3,
        RG_EXT_W1      = 3'd4,
        RG_EXT_W2      = 3'd5,
        RG_EXT_W3      = 3'd6,
        RG_EXT_MUXED   = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             is_byte;
        logic [1:0]       n_acc;
        logic [MUL_W-1:0] mul;
    } side_plan_t;

    function automatic logic [MUL_W-1:0] region_mul(region_e r);
        logic [MUL_W-1:0] m;
        case (r)
            RG_ONCHIP_FAST: m = MUL_W'(1);
            RG_ONCHIP_SLOW: m = MUL_W'(2);
            RG_CTRL_SPACE:  m = MUL_W'(2);
            RG_EXT_W0:      m = MUL_W'(1);
            RG_EXT_W1:      m = MUL_W'(2);
            RG_EXT_W2:      m = MUL_W'(3);
            RG_EXT_W3:      m = MUL_W'(4);
            default:        m = MUL_W'(3);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_access_planner.sv
module dma_access_planner
    import dma_seq_pkg::*;
(
    input  logic       word_unit,
    input  logic       wide_bus,
    input  logic       addr_lsb,
    input  region_e    region,
    output side_plan_t plan
);

    always_comb begin
        logic split;
        split        = word_unit && (!wide_bus || addr_lsb);
        plan.is_byte = !word_unit || split;
        plan.n_acc   = split ? 2'd2 : 2'd1;
        plan.mul     = region_mul(region);
    end

endmodule

// File: rtl/dma_wait_timer.sv
module dma_wait_timer
    import dma_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [MUL_W-1:0] mul,
    output logic             last
);

    logic [MUL_W-1:0] cnt_q;

    assign last = run && (cnt_q == mul);

    always_ff @(posedge clk) begin
        if (rst || !run || last) begin
            cnt_q <= MUL_W'(1);
        end else begin
            cnt_q <= cnt_q + MUL_W'(1);
        end
    end

    // R6: an access never runs past its region's clock count
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q >= MUL_W'(1) && cnt_q <= mul));

endmodule

// File: rtl/dma_word_buffer.sv
module dma_word_buffer
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              cap_word,
    input  logic              cap_hi,
    input  logic [DATA_W-1:0] rdata,
    input  logic              wr_word,
    input  logic              wr_hi,
    output logic [DATA_W-1:0] wdata
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (cap) begin
            if (cap_word) begin
                hold_q <= rdata;
            end else if (cap_hi) begin
                hold_q[DATA_W-1:HALF] <= rdata[HALF-1:0];
            end else begin
                hold_q[HALF-1:0] <= rdata[HALF-1:0];
            end
        end
    end

    always_comb begin
        if (wr_word) begin
            wdata = hold_q;
        end else if (wr_hi) begin
            wdata = {{HALF{1'b0}}, hold_q[DATA_W-1:HALF]};
        end else begin
            wdata = {{HALF{1'b0}}, hold_q[HALF-1:0]};
        end
    end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 24
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              unit_word,
    input  logic              bus_wide,
    input  logic [2:0]        src_region,
    input  logic [2:0]        dst_region,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_byte,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [TOT_W-1:0]  cycles
);

    localparam int SIDES = 2;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] side_addr_q [SIDES];
    logic [2:0]        side_reg_q  [SIDES];
    side_plan_t        plan        [SIDES];
    logic              word_q;
    logic              wide_q;
    logic              idx_q;
    logic [TOT_W-1:0]  cycles_q;

    logic              side;
    side_plan_t        cur;
    logic              acc_last;
    logic              side_last;

    generate
        for (genvar g = 0; g < SIDES; g++) begin : g_side
            dma_access_planner u_plan (
                .word_unit (word_q),
                .wide_bus  (wide_q),
                .addr_lsb  (side_addr_q[g][0]),
                .region    (region_e'(side_reg_q[g])),
                .plan      (plan[g])
            );
        end
    endgenerate

    assign side      = (state_q == ST_WRITE);
    assign cur       = plan[side];
    assign bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign bus_we    = side;
    assign bus_byte  = cur.is_byte;
    assign bus_addr  = side_addr_q[side] + ADDR_W'(idx_q);
    assign side_last = ({1'b0, idx_q} == (cur.n_acc - 2'd1));
    assign busy      = bus_req;
    assign done      = (state_q == ST_DONE);
    assign cycles    = cycles_q;

    dma_wait_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (bus_req),
        .mul  (cur.mul),
        .last (acc_last)
    );

    dma_word_buffer u_buf (
        .clk      (clk),
        .rst      (rst),
        .cap      ((state_q == ST_READ) && acc_last),
        .cap_word (!plan[0].is_byte),
        .cap_hi   (idx_q),
        .rdata    (bus_rdata),
        .wr_word  (!plan[1].is_byte),
        .wr_hi    (idx_q),
        .wdata    (bus_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            idx_q          <= 1'b0;
            cycles_q       <= '0;
            word_q         <= 1'b0;
            wide_q         <= 1'b0;
            side_addr_q[0] <= '0;
            side_addr_q[1] <= '0;
            side_reg_q[0]  <= '0;
            side_reg_q[1]  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        side_addr_q[0] <= src_addr;
                        side_addr_q[1] <= dst_addr;
                        side_reg_q[0]  <= src_region;
                        side_reg_q[1]  <= dst_region;
                        word_q         <= unit_word;
                        wide_q         <= bus_wide;
                        idx_q          <= 1'b0;
                        cycles_q       <= '0;
                        state_q        <= ST_READ;
                    end
                end
                ST_READ, ST_WRITE: begin
                    cycles_q <= cycles_q + TOT_W'(1);
                    if (acc_last) begin
                        if (side_last) begin
                            idx_q   <= 1'b0;
                            state_q <= (state_q == ST_READ) ? ST_WRITE : ST_DONE;
                        end else begin
                            idx_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: no read follows a write within a unit
    p_reads_first_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> !(bus_req && !bus_we));

    // R6: control lines hold until the access's final clock
    p_access_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !acc_last) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_byte)));

    // R8: done lasts one clock
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done comes straight after a write clock
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_req && bus_we));

    // R8: count holds while idle and no start
    p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(cycles));

endmodule

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;
    import dma_seq_pkg::*;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] src_addr = '0;
    logic [AW-1:0] dst_addr = '0;
    logic          unit_word = 1'b0;
    logic          bus_wide = 1'b0;
    logic [2:0]    src_region = '0;
    logic [2:0]    dst_region = '0;
    logic          bus_req, bus_we, bus_byte, busy, done;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;
    logic [TOT_W-1:0] cycles;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign bus_rdata = bus_byte ? {8'h00, mem_byte(bus_addr)}
                                : {mem_byte(bus_addr + 1), mem_byte(bus_addr)};

    dma_xfer_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .unit_word(unit_word), .bus_wide(bus_wide),
        .src_region(src_region), .dst_region(dst_region),
        .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .cycles(cycles)
    );

    function automatic int ref_mul(logic [2:0] r);
        case (r)
            3'd0: return 1;  3'd1: return 2;  3'd2: return 2;  3'd3: return 1;
            3'd4: return 2;  3'd5: return 3;  3'd6: return 4;  default: return 3;
        endcase
    endfunction

    task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_unit(input string tag, input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input logic w, input logic wb, input logic [2:0] sr,
                            input logic [2:0] dr, input bit poke);
        logic [15:0] val;
        int   cyc;
        int   total;
        bit   split [2];
        int   nacc  [2];
        int   mul   [2];
        logic [AW-1:0] base [2];
        base[0] = s; base[1] = d;
        mul[0] = ref_mul(sr); mul[1] = ref_mul(dr);
        for (int k = 0; k < 2; k++) begin
            split[k] = w && (!wb || base[k][0]);
            nacc[k]  = split[k] ? 2 : 1;
        end
        val   = w ? {mem_byte(s + 1), mem_byte(s)} : {8'h00, mem_byte(s)};
        total = nacc[0] * mul[0] + nacc[1] * mul[1];

        @(negedge clk);
        src_addr = s; dst_addr = d; unit_word = w; bus_wide = wb;
        src_region = sr; dst_region = dr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        for (int k = 0; k < 2; k++) begin
            for (int a = 0; a < nacc[k]; a++) begin
                for (int c = 0; c < mul[k]; c++) begin
                    logic [AW-1:0] ea;
                    logic          eb;
                    logic [15:0]   ew;
                    ea = base[k] + AW'(a);
                    eb = !w || split[k];
                    if (!eb)        ew = val;
                    else if (a == 1) ew = {8'h00, val[15:8]};
                    else             ew = {8'h00, val[7:0]};
                    check($sformatf("%s/R6 access ctl", tag),
                          bus_req === 1'b1 && bus_we === 1'(k) && bus_byte === eb && busy === 1'b1 && done === 1'b0,
                          {bus_req, bus_we, bus_byte, busy, done}, {1'b1, 1'(k), eb, 1'b1, 1'b0});
                    check($sformatf("%s/R5 addr", tag), bus_addr === ea, bus_addr, ea);
                    if (k == 1)
                        check($sformatf("%s/R7 wdata", tag), bus_wdata === ew, bus_wdata, ew);
                    if (poke && cyc == 2) begin
                        start = 1'b1; src_addr = s ^ 24'h0F0F0F; dst_addr = d + 24'h100;
                        unit_word = !w; bus_wide = !wb; src_region = 3'd6; dst_region = 3'd6;
                    end
                    @(negedge clk);
                    start = 1'b0;
                    cyc++;
                end
            end
        end
        check($sformatf("%s/R8 done pulse", tag), done === 1'b1 && bus_req === 1'b0 && busy === 1'b0,
              {done, bus_req, busy}, 3'b100);
        check($sformatf("%s/R1 cycle total", tag), cycles === TOT_W'(total), cycles, total);
        check($sformatf("%s/R5 clock count", tag), cyc == total, cyc, total);
        @(negedge clk);
        check($sformatf("%s/R8 done low, count held", tag),
              done === 1'b0 && bus_req === 1'b0 && cycles === TOT_W'(total),
              {done, bus_req, cycles}, {2'b00, TOT_W'(total)});
    endtask

    always @(posedge clk) begin
        ticks++;
        if (ticks > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", ticks);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset idle", bus_req === 1'b0 && busy === 1'b0 && done === 1'b0 && cycles === '0,
              {bus_req, busy, done, cycles}, '0);

        run_unit("R2 byte wide",   24'h000100, 24'h000203, 1'b0, 1'b1, 3'd0, 3'd3, 1'b0);
        run_unit("R2 byte narrow", 24'h000311, 24'h000400, 1'b0, 1'b0, 3'd2, 3'd7, 1'b0);
        run_unit("R3 word even",   24'h001000, 24'h002002, 1'b1, 1'b1, 3'd1, 3'd6, 1'b0);
        run_unit("R4 odd src",     24'h001235, 24'h004440, 1'b1, 1'b1, 3'd4, 3'd5, 1'b0);
        run_unit("R4 narrow bus",  24'h005550, 24'h006660, 1'b1, 1'b0, 3'd7, 3'd6, 1'b0);
        run_unit("R4 odd dst",     24'h0077A0, 24'h0088B1, 1'b1, 1'b1, 3'd0, 3'd2, 1'b0);
        run_unit("R9 busy start",  24'h009902, 24'h00AAA3, 1'b1, 1'b0, 3'd6, 3'd5, 1'b1);
        for (int r = 0; r < 8; r++)
            run_unit("R1 region sweep", 24'h00C000 + AW'(r * 2), 24'h00D000 + AW'(r * 4),
                     1'b1, 1'b1, 3'(r), 3'(7 - r), 1'b0);
        run_unit("R3 odd-odd split", 24'h00E001, 24'h00F003, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule